// File: doc/BRIEF.md
# Page Hamming ECC generator

This block sits beside the byte path of a NAND flash controller and builds a single-error-correcting Hamming parity over the data as it streams past. The page is divided into fixed 256-byte chunks. The block keeps its own position inside the current chunk and folds each accepted byte into a 22-bit raw parity word. When the last byte of a chunk arrives, it publishes the finished word for one cycle and starts the next chunk from zero without any outside help. A 512-byte page therefore yields two codes and a 2048-byte page yields eight.

Each code protects one chunk and can correct one flipped bit in it. Three bytes of spare area hold each code, so the two codes of a small page fill the last six bytes of a 16-byte spare area (offsets 10 to 15). For that storage the block also presents a formatted 24-bit form of the code. The enable input gates accumulation. The clear strobe discards a partial chunk. Comparing syndromes and correcting data are left to other logic.

Control is a two-state machine. `ST_EMPTY` means no byte of the current chunk has been taken yet. `ST_FILL` means at least one byte has been taken. The transitions are:
- `EMPTY->FILL`: a byte is accepted.
- `FILL->EMPTY` (wrap): the final byte of the chunk is accepted.
- `FILL->EMPTY` (clear): the clear strobe is seen.
- `EMPTY->EMPTY` (hold): the cycle has no accepted byte, or the clear strobe is seen.
- `FILL->FILL` (advance or hold): any other cycle.

Top module: `page_hamming_ecc`

## Requirements
- R1: Line parity: for each byte-address bit k (0..7) within the chunk, `code_raw[6+2k]` is the XOR of all data bits of bytes whose address bit k is 0, and `code_raw[7+2k]` is the XOR of all data bits of bytes whose address bit k is 1.
- R2: Column parity: for m in 0..2 (bit-position weights 1, 2, 4), `code_raw[2m]` is the XOR over the chunk of data bits whose bit index has bit m clear, and `code_raw[2m+1]` is the XOR of those whose bit index has bit m set.
- R3: `code_vld` is high for exactly one cycle, in the cycle after the edge that accepts the 256th byte of a chunk. `code_raw` takes the new code in that same cycle.
- R4: The byte position wraps to 0 after each chunk. Consecutive chunks, including eight back-to-back chunks of a 2048-byte page, each produce a code computed only from their own bytes, and no code appears before a chunk is complete.
- R5: A byte is accepted only when `byte_vld` and `ecc_en` are both high. Bytes offered while `ecc_en` is low change neither the parity nor the byte position.
- R6: `ecc_clr` zeroes the parity, the byte position and `code_raw` at the next edge. A byte offered in the same cycle is dropped. If that byte would have completed a chunk, no code is emitted.
- R7: `code_fmt` equals the bitwise inverse of `{code_raw, 2'b00}`. `code_fmt[23:16]` is the byte stored first (lowest spare offset), then `[15:8]`, then `[7:0]`.
- R8: `code_raw` keeps its value until the next chunk completes or a clear occurs.
- R9: After reset, `code_vld` is 0, `code_raw` is 0 and `code_fmt` is 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Accumulation enable |
| ecc_clr | input | 1 | Clear strobe for parity, position and held code |
| byte_vld | input | 1 | A data byte is on `byte_dat` this cycle |
| byte_dat | input | 8 | Data byte on the NAND path |
| code_vld | output | 1 | One-cycle pulse: a finished chunk code is on `code_raw` |
| code_raw | output | 22 | Raw line and column parity of the last chunk |
| code_fmt | output | 24 | Inverted, shifted form for spare-area storage |

## Verification
Two events can fall in the same cycle: completing a chunk and the clear strobe. The bench feeds 255 bytes and then drives the 256th byte with `ecc_clr` high in the same cycle. It judges the result by three things: no pulse on `code_vld`, a zeroed `code_raw`, and a following full chunk that produces its code exactly at its own 256th byte. Clear in the middle of a chunk, and disabled bytes mixed into a chunk, are judged the same way: by when the next pulse arrives and by the parity it carries, compared against a bit-level reference model.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FILL  = 1'b1
    } fill_state_t;

endpackage

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
    import hecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    parameter int CNT_W       = $clog2(CHUNK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             byte_vld,
    output logic             take,
    output logic             last,
    output logic             restart,
    output logic [CNT_W-1:0] addr
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHUNK_BYTES - 1);

    fill_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             take_w;

    assign take_w = en & byte_vld & ~clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (take_w) begin
                    state_d = ST_FILL;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_FILL: begin
                if (clr) begin
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end else if (take_w && cnt_q == LAST_IDX) begin
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end else if (take_w) begin
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        take    = take_w;
        addr    = cnt_q;
        last    = take_w && (state_q == ST_FILL) && (cnt_q == LAST_IDX);
        restart = clr | last;
    end

endmodule

// File: rtl/hecc_parity_acc.sv
module hecc_parity_acc #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int COL_W  = $clog2(DATA_W),
    parameter int RAW_W  = 2 * (ADDR_W + COL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              restart,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [RAW_W-1:0]  nxt_raw
);
    localparam int LINE_BASE = 2 * COL_W;

    function automatic logic [DATA_W-1:0] upper_mask(input int m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = ((i >> m) & 1) == 1;
        end
        return r;
    endfunction

    logic [RAW_W-1:0] acc_q;
    logic [RAW_W-1:0] contrib;
    logic             byte_par;

    assign byte_par = ^data;

    for (genvar m = 0; m < COL_W; m++) begin : g_col
        localparam logic [DATA_W-1:0] HI = upper_mask(m);
        assign contrib[2*m]     = ^(data & ~HI);
        assign contrib[2*m + 1] = ^(data & HI);
    end

    for (genvar k = 0; k < ADDR_W; k++) begin : g_line
        assign contrib[LINE_BASE + 2*k]     = byte_par & ~addr[k];
        assign contrib[LINE_BASE + 2*k + 1] = byte_par & addr[k];
    end

    assign nxt_raw = take ? (acc_q ^ contrib) : acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= acc_q ^ contrib;
        end
    end

endmodule

// File: rtl/hecc_out_reg.sv
module hecc_out_reg #(
    parameter int RAW_W = 22,
    parameter int FMT_W = RAW_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             last,
    input  logic [RAW_W-1:0] nxt_raw,
    output logic             code_vld,
    output logic [RAW_W-1:0] code_raw,
    output logic [FMT_W-1:0] code_fmt
);
    logic [RAW_W-1:0] raw_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            vld_q <= 1'b0;
        end else if (clr) begin
            raw_q <= '0;
            vld_q <= 1'b0;
        end else if (last) begin
            raw_q <= nxt_raw;
            vld_q <= 1'b1;
        end else begin
            vld_q <= 1'b0;
        end
    end

    assign code_vld = vld_q;
    assign code_raw = raw_q;
    assign code_fmt = ~{raw_q, 2'b00};

endmodule

// File: rtl/page_hamming_ecc.sv
module page_hamming_ecc #(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256,
    parameter int ADDR_W      = $clog2(CHUNK_BYTES),
    parameter int COL_W       = $clog2(DATA_W),
    parameter int RAW_W       = 2 * (ADDR_W + COL_W),
    parameter int FMT_W       = RAW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              ecc_clr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_dat,
    output logic              code_vld,
    output logic [RAW_W-1:0]  code_raw,
    output logic [FMT_W-1:0]  code_fmt
);
    logic              take, last, restart;
    logic [ADDR_W-1:0] addr;
    logic [RAW_W-1:0]  nxt_raw;

    hecc_ctrl #(
        .CHUNK_BYTES(CHUNK_BYTES),
        .CNT_W      (ADDR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ecc_en),
        .clr     (ecc_clr),
        .byte_vld(byte_vld),
        .take    (take),
        .last    (last),
        .restart (restart),
        .addr    (addr)
    );

    hecc_parity_acc #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .COL_W (COL_W),
        .RAW_W (RAW_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .restart(restart),
        .addr   (addr),
        .data   (byte_dat),
        .nxt_raw(nxt_raw)
    );

    hecc_out_reg #(
        .RAW_W(RAW_W),
        .FMT_W(FMT_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ecc_clr),
        .last    (last),
        .nxt_raw (nxt_raw),
        .code_vld(code_vld),
        .code_raw(code_raw),
        .code_fmt(code_fmt)
    );

endmodule

// File: rtl/page_hamming_ecc_chk.sv
module page_hamming_ecc_chk #(
    parameter int CHUNK_BYTES = 256,
    parameter int ADDR_W      = 8,
    parameter int RAW_W       = 22,
    parameter int FMT_W       = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ecc_en,
    input logic             ecc_clr,
    input logic             byte_vld,
    input logic             code_vld,
    input logic [RAW_W-1:0] code_raw,
    input logic [FMT_W-1:0] code_fmt
);
    localparam logic [ADDR_W:0] FULL = (ADDR_W + 1)'(CHUNK_BYTES);

    logic [ADDR_W:0] seen_q, seen_base;
    logic            took;

    assign took      = ecc_en & byte_vld & ~ecc_clr;
    assign seen_base = (seen_q == FULL) ? '0 : seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= '0;
        else if (ecc_clr) seen_q <= '0;
        else if (took)    seen_q <= seen_base + 1'b1;
        else              seen_q <= seen_base;
    end

    // R3: a finished chunk yields exactly one pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> !code_vld);

    // R3 / R4: pulse appears exactly when a full chunk has been accepted
    a_r3_pulse_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == FULL) |-> code_vld);
    a_r4_no_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> (seen_q == FULL));

    // R5: a disabled cycle never completes a chunk
    a_r5_disabled_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> !code_vld);

    // R6: clear zeroes the held code and suppresses the pulse
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (!code_vld && code_raw == '0));

    // R7: the two lowest formatted bits are always ones
    a_r7_fmt_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
        code_fmt[1:0] == 2'b11);

    // R8: the code only moves on a pulse or after a clear
    a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_clr |=> (code_vld || $stable(code_raw)));

endmodule

bind page_hamming_ecc page_hamming_ecc_chk #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .ADDR_W     (ADDR_W),
    .RAW_W      (RAW_W),
    .FMT_W      (FMT_W)
) u_chk (.*);

// File: tb/tb_page_hamming_ecc.sv
`timescale 1ns/1ps
module tb_page_hamming_ecc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ecc_en, ecc_clr, byte_vld;
    logic [7:0]  byte_dat;
    logic        code_vld;
    logic [21:0] code_raw;
    logic [23:0] code_fmt;

    int          n_chk = 0;
    int          n_err = 0;
    logic [7:0]  blk [256];
    logic [21:0] exp_raw;
    bit          pend = 1'b0;

    always #4 clk = ~clk;

    page_hamming_ecc dut (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
        .byte_vld(byte_vld), .byte_dat(byte_dat),
        .code_vld(code_vld), .code_raw(code_raw), .code_fmt(code_fmt)
    );

    function automatic logic [21:0] ref_code();
        logic [21:0] r = '0;
        for (int i = 0; i < 256; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (blk[i][b]) begin
                    for (int k = 0; k < 8; k++)
                        if ((i >> k) & 1) r[7 + 2*k] = ~r[7 + 2*k];
                        else              r[6 + 2*k] = ~r[6 + 2*k];
                    for (int m = 0; m < 3; m++)
                        if ((b >> m) & 1) r[2*m + 1] = ~r[2*m + 1];
                        else              r[2*m]     = ~r[2*m];
                end
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        chk(code_vld == 1'b1, "R3 pulse after 256th byte", 32'(code_vld), 1);
        chk(code_raw == exp_raw, "R1 R2 raw parity", 32'(code_raw), 32'(exp_raw));
        chk(code_fmt == ~{exp_raw, 2'b00}, "R7 formatted code", 32'(code_fmt),
            32'(~{exp_raw, 2'b00}));
        pend = 1'b0;
    endtask

    task automatic feed_chunk(input int gap);
        int early = 0;
        for (int i = 0; i < 256; i++) begin
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                @(negedge clk);
                if (pend) settle(); else if (code_vld) early++;
                ecc_en = 1'b0; byte_vld = 1'b1; byte_dat = 8'($urandom);
            end
            @(negedge clk);
            if (pend) settle(); else if (code_vld) early++;
            ecc_en = 1'b1; byte_vld = 1'b1; byte_dat = blk[i];
        end
        chk(early == 0, "R4 no code before chunk end", 32'(early), 0);
        exp_raw = ref_code();
        pend = 1'b1;
    endtask

    task automatic close_chunk();
        @(negedge clk);
        if (pend) settle();
        byte_vld = 1'b0; ecc_en = 1'b1;
    endtask

    task automatic feed_part(input int n);
        int early = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (code_vld) early++;
            ecc_en = 1'b1; byte_vld = 1'b1; byte_dat = 8'($urandom);
        end
        chk(early == 0, "R6 partial chunk gives no code", 32'(early), 0);
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 256; i++) blk[i] = 8'($urandom);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ecc_en = 1'b0; ecc_clr = 1'b0; byte_vld = 1'b0; byte_dat = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_vld == 1'b0, "R9 reset valid", 32'(code_vld), 0);
        chk(code_raw == '0, "R9 reset raw", 32'(code_raw), 0);
        chk(code_fmt == 24'hFFFFFF, "R9 reset formatted", 32'(code_fmt), 32'hFFFFFF);
    endtask

    task automatic t_known();
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
        blk[0] = 8'h01;
        feed_chunk(0); close_chunk();
        chk(code_raw == 22'h155555, "R1 R2 bit0 at address 0", 32'(code_raw), 32'h155555);
        chk(code_fmt == 24'hAAAAAB, "R7 bit0 at address 0", 32'(code_fmt), 32'hAAAAAB);
        blk[0] = 8'h00; blk[255] = 8'h80;
        feed_chunk(0); close_chunk();
        chk(code_raw == 22'h2AAAAA, "R1 R2 bit7 at address 255", 32'(code_raw), 32'h2AAAAA);
        chk(code_fmt == 24'h555557, "R7 bit7 at address 255", 32'(code_fmt), 32'h555557);
        blk[255] = 8'h00;
        feed_chunk(0); close_chunk();
        chk(code_fmt == 24'hFFFFFF, "R7 all-zero chunk", 32'(code_fmt), 32'hFFFFFF);
        for (int i = 0; i < 256; i++) blk[i] = 8'(i);
        feed_chunk(0); close_chunk();
    endtask

    task automatic t_page(input int chunks);
        for (int c = 0; c < chunks; c++) begin
            fill_rand();
            feed_chunk(0);
        end
        close_chunk();
    endtask

    task automatic t_enable();
        logic [21:0] held;
        int bad = 0;
        fill_rand();
        feed_chunk(7); close_chunk();
        held = code_raw;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (code_vld || code_raw != held) bad++;
            ecc_en = 1'b0; byte_vld = 1'b1; byte_dat = 8'($urandom);
        end
        @(negedge clk);
        byte_vld = 1'b0; ecc_en = 1'b1;
        chk(bad == 0, "R5 R8 disabled bytes leave code held", 32'(bad), 0);
        fill_rand();
        feed_chunk(0); close_chunk();
    endtask

    task automatic t_clear_mid();
        feed_part(100);
        @(negedge clk);
        ecc_clr = 1'b1; byte_vld = 1'b1; byte_dat = 8'hA5;
        @(negedge clk);
        ecc_clr = 1'b0; byte_vld = 1'b0;
        chk(code_raw == '0, "R6 clear zeroes code", 32'(code_raw), 0);
        chk(code_vld == 1'b0, "R6 clear no pulse", 32'(code_vld), 0);
        fill_rand();
        feed_chunk(0); close_chunk();
    endtask

    task automatic t_clear_last();
        feed_part(255);
        @(negedge clk);
        ecc_clr = 1'b1; byte_vld = 1'b1; byte_dat = 8'h3C;
        @(negedge clk);
        chk(code_vld == 1'b0, "R6 clear beats completion", 32'(code_vld), 0);
        chk(code_raw == '0, "R6 clear beats completion raw", 32'(code_raw), 0);
        ecc_clr = 1'b0; byte_vld = 1'b0;
        fill_rand();
        feed_chunk(0); close_chunk();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_known();
        t_page(2);
        t_page(8);
        t_enable();
        t_clear_mid();
        t_clear_last();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule